// File: doc/BRIEF.md
# Smart card power sequencer

This block brings a contact smart card up and takes it down again in a fixed order. The host opens a session by pulling an active-low request line. The block then turns on, step by step, the voltage pump enable, the card supply enable, the data-line buffer enable, the card clock gate and finally the card reset path. When the host releases the request, the same outputs are switched off in reverse order. The same shutdown also runs on its own when the card is pulled out or when a fault flag rises. The analog pump, regulator, thermal and current sensors sit outside the block and report to it only through digital flags.

All step timing counts in half-units of T, where T is 64 oscillator cycles; `HALF_T` is the number of clock cycles in half a unit. After the supply-good flag rises, the block stays inactive for `HOLD_CYC` cycles. The host watches an active-high status output. Outside a session it shows whether a card is inserted. During a session it drops when a fault is detected, and stays low until the host releases the request.

Top module: `smartcard_seq`

In the requirements, H means `HALF_T`. "Edge k" means the k-th rising clock edge after the reference edge, which is edge 0. The session request is active low. A card is present when `pres_ni` is 0 or `pres_i` is 1.

## Requirements
- R1: During and after reset, with no request made, pump, supply, data-line, clock and card-reset outputs are all 0, and `irq_o` equals card presence.
- R2: While no session is open and no latched fault exists, `irq_o` is 1 when `pres_ni`=0 or `pres_i`=1, and 0 otherwise.
- R3: A session starts at a clock edge only if all of these hold: the block is idle, the request was 1 at the previous edge, the request is 0 now, a card is present and the power-up hold has expired. Otherwise the request is ignored.
- R4: On the accepting edge (edge 0), `pump_en_o` goes to 1. `vcc_en_o` goes to 1 at edge 3H+1 and `io_en_o` at edge 8H+1. The session becomes fully active at edge 14H+1.
- R5: If `host_rst_i` is 0 at the accepting edge, `clk_en_o` goes to 1 together with `io_en_o`. Otherwise it goes to 1 at the first edge from 8H+1 on at which `host_rst_i` is sampled 0, and at edge 14H+1 at the latest.
- R6: Once the session is fully active, `card_rst_o` copies `host_rst_i` with one clock of delay, and `host_rst_i` has no effect on `clk_en_o`.
- R7: Shutdown begins at a reference edge D (edge 0). `card_rst_o` is 0 from D. `clk_en_o` drops at edge H+1, `io_en_o` at 2H+1 and `vcc_en_o` at 3H+1. `pump_en_o` drops at 10H+1, where the block becomes idle.
- R8: Shutdown starts during activation or an active session when any of these is seen: the request goes high, the card is absent, `ocp_i`=1, `otp_i`=1 or `supply_ok_i`=0.
- R9: During a session, card absence, `ocp_i` or `otp_i` drives `irq_o` to 0 from the next edge. It stays 0 until the request is sampled 1, even if the card returns. A supply drop leaves `irq_o` at 1.
- R10: The power-up hold is loaded with `HOLD_CYC` while `supply_ok_i`=0 (and at reset). It counts down one per clock while `supply_ok_i`=1. A request made while the hold is running starts no session.
- R11: If shutdown starts during activation, any output not yet enabled stays 0 throughout the shutdown.
- R12: After a session ends, or after a request was ignored, a new session needs the block to be idle and the request to go from 1 to 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sess_req_ni | input | 1 | Session request from host, active low |
| host_rst_i | input | 1 | Card reset request from host |
| pres_ni | input | 1 | Card presence switch, active low |
| pres_i | input | 1 | Card presence switch, active high |
| supply_ok_i | input | 1 | Logic supply within range |
| ocp_i | input | 1 | Card supply overcurrent flag |
| otp_i | input | 1 | Overtemperature flag |
| pump_en_o | output | 1 | Voltage pump enable |
| vcc_en_o | output | 1 | Card supply enable |
| io_en_o | output | 1 | Data-line buffer enable |
| clk_en_o | output | 1 | Card clock gate enable |
| card_rst_o | output | 1 | Card reset line |
| irq_o | output | 1 | Host status: 1 = card present / no fault |

## Verification
Some properties are checked on every cycle. The enables always nest: supply implies pump, data lines imply supply, clock implies data lines, and card reset implies clock. Card reset stays low throughout shutdown. A session never starts without a card or while the hold runs. The status output behaves as specified on the cycle after a fault or a supply drop. The exact edge of each step, the choice of clock start, and the shutdown of a partly activated card depend on the stimulus history. The bench's reference model shows these against the scenarios. The latched status after the card returns, and requests ignored while the card is absent or the hold runs, are also shown there.

// File: rtl/scs_pkg.sv
package scs_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ACT, ST_ON, ST_DEACT} seq_state_e;

  // step positions in half-T units from the start of each sequence
  localparam int unsigned STEP_VCC_ON   = 3;
  localparam int unsigned STEP_IO_ON    = 8;
  localparam int unsigned STEP_RST_ON   = 14;
  localparam int unsigned STEP_CLK_OFF  = 1;
  localparam int unsigned STEP_IO_OFF   = 2;
  localparam int unsigned STEP_VCC_OFF  = 3;
  localparam int unsigned STEP_PUMP_OFF = 10;
  localparam int unsigned STEP_W        = $clog2(STEP_RST_ON + 1);
endpackage

// File: rtl/scs_halftick.sv
module scs_halftick #(
  parameter int unsigned HALF_T = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic strobe_o
);
  localparam int unsigned CW = (HALF_T > 1) ? $clog2(HALF_T) : 1;

  logic [CW-1:0] cnt_q;

  assign strobe_o = run_i && (cnt_q == CW'(HALF_T - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (restart_i || !run_i || strobe_o) cnt_q <= '0;
    else                                  cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/scs_monitor.sv
module scs_monitor #(
  parameter int unsigned HOLD_CYC = 25000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pres_ni,
  input  logic pres_i,
  input  logic supply_ok_i,
  input  logic ocp_i,
  input  logic otp_i,
  input  logic sess_req_ni,
  input  logic in_sess_i,
  input  logic busy_i,
  output logic present_o,
  output logic hold_o,
  output logic irq_o
);
  localparam int unsigned HW = $clog2(HOLD_CYC + 1);

  logic [HW-1:0] hold_q;
  logic          flt_q;

  assign present_o = !pres_ni || pres_i;
  assign hold_o    = (hold_q != '0);
  assign irq_o     = flt_q ? 1'b0 : (busy_i ? 1'b1 : present_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          hold_q <= HW'(HOLD_CYC);
    else if (!supply_ok_i) hold_q <= HW'(HOLD_CYC);
    else if (hold_o)      hold_q <= hold_q - HW'(1);
  end

  // removal / overcurrent / overtemperature memorised until request released
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          flt_q <= 1'b0;
    else if (sess_req_ni) flt_q <= 1'b0;
    else if (in_sess_i && (!present_o || ocp_i || otp_i)) flt_q <= 1'b1;
  end

  AST_SUPPLY_DROP_KEEPS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_sess_i && !supply_ok_i && present_o && !ocp_i && !otp_i && !sess_req_ni) |=> irq_o); // R9
  AST_FAULT_DROPS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_sess_i && (ocp_i || otp_i) && !sess_req_ni) |=> !irq_o); // R9
  AST_HOLD_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> hold_o); // R10
endmodule

// File: rtl/scs_fsm.sv
module scs_fsm
  import scs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sess_req_ni,
  input  logic host_rst_i,
  input  logic present_i,
  input  logic hold_i,
  input  logic supply_ok_i,
  input  logic ocp_i,
  input  logic otp_i,
  input  logic strobe_i,
  output logic run_o,
  output logic restart_o,
  output logic in_sess_o,
  output logic busy_o,
  output logic pump_en_o,
  output logic vcc_en_o,
  output logic io_en_o,
  output logic clk_en_o,
  output logic card_rst_o
);
  seq_state_e        state_q;
  logic [STEP_W-1:0] halves_q;
  logic              armed_q, rst_at_start_q;
  logic              pump_q, vcc_q, io_q, clk_q, crst_q;
  logic              accept, abort;

  function automatic logic at_step(logic [STEP_W-1:0] h, int unsigned s);
    return h >= STEP_W'(s);
  endfunction

  assign in_sess_o = (state_q == ST_ACT) || (state_q == ST_ON);
  assign busy_o    = (state_q != ST_IDLE);
  assign run_o     = (state_q == ST_ACT) || (state_q == ST_DEACT);
  assign abort     = in_sess_o && (sess_req_ni || !present_i || ocp_i || otp_i || !supply_ok_i);
  assign accept    = (state_q == ST_IDLE) && armed_q && !sess_req_ni && present_i && !hold_i;
  assign restart_o = accept || abort;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= ST_IDLE;
      halves_q       <= '0;
      armed_q        <= 1'b0;
      rst_at_start_q <= 1'b0;
      pump_q         <= 1'b0;
      vcc_q          <= 1'b0;
      io_q           <= 1'b0;
      clk_q          <= 1'b0;
      crst_q         <= 1'b0;
    end else begin
      // a fresh high-to-low request is required while idle
      armed_q <= (state_q == ST_IDLE) && sess_req_ni;
      crst_q  <= (state_q == ST_ON) && !abort && host_rst_i;
      if (restart_o)     halves_q <= '0;
      else if (strobe_i) halves_q <= halves_q + STEP_W'(1);
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q        <= ST_ACT;
          pump_q         <= 1'b1;
          rst_at_start_q <= host_rst_i;
        end
        ST_ACT: if (abort) begin
          state_q <= ST_DEACT;
        end else begin
          if (at_step(halves_q, STEP_VCC_ON)) vcc_q <= 1'b1;
          if (at_step(halves_q, STEP_IO_ON))  io_q  <= 1'b1;
          if (at_step(halves_q, STEP_IO_ON) &&
              (!rst_at_start_q || !host_rst_i || at_step(halves_q, STEP_RST_ON)))
            clk_q <= 1'b1;
          if (at_step(halves_q, STEP_RST_ON)) state_q <= ST_ON;
        end
        ST_ON: if (abort) state_q <= ST_DEACT;
        ST_DEACT: begin
          if (at_step(halves_q, STEP_CLK_OFF)) clk_q <= 1'b0;
          if (at_step(halves_q, STEP_IO_OFF))  io_q  <= 1'b0;
          if (at_step(halves_q, STEP_VCC_OFF)) vcc_q <= 1'b0;
          if (at_step(halves_q, STEP_PUMP_OFF)) begin
            pump_q  <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign pump_en_o  = pump_q;
  assign vcc_en_o   = vcc_q;
  assign io_en_o    = io_q;
  assign clk_en_o   = clk_q;
  assign card_rst_o = crst_q;

  AST_VCC_NEEDS_PUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vcc_q |-> pump_q); // R4
  AST_IO_NEEDS_VCC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_q |-> vcc_q); // R7
  AST_CLK_NEEDS_IO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_q |-> io_q); // R5
  AST_RST_NEEDS_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crst_q |-> clk_q); // R6
  AST_RST_LOW_IN_DEACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DEACT) |-> !crst_q); // R7
  AST_START_GUARDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pump_q) |-> $past(present_i && !hold_i && !sess_req_ni)); // R3
endmodule

// File: rtl/smartcard_seq.sv
module smartcard_seq #(
  parameter int unsigned HALF_T   = 32,
  parameter int unsigned HOLD_CYC = 25000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sess_req_ni,
  input  logic host_rst_i,
  input  logic pres_ni,
  input  logic pres_i,
  input  logic supply_ok_i,
  input  logic ocp_i,
  input  logic otp_i,
  output logic pump_en_o,
  output logic vcc_en_o,
  output logic io_en_o,
  output logic clk_en_o,
  output logic card_rst_o,
  output logic irq_o
);
  logic present, hold, strobe, run, restart, in_sess, busy;

  scs_halftick #(.HALF_T(HALF_T)) u_tick (
    .clk_i, .rst_ni, .run_i(run), .restart_i(restart), .strobe_o(strobe)
  );

  scs_monitor #(.HOLD_CYC(HOLD_CYC)) u_mon (
    .clk_i, .rst_ni, .pres_ni, .pres_i, .supply_ok_i, .ocp_i, .otp_i,
    .sess_req_ni, .in_sess_i(in_sess), .busy_i(busy),
    .present_o(present), .hold_o(hold), .irq_o
  );

  scs_fsm u_fsm (
    .clk_i, .rst_ni, .sess_req_ni, .host_rst_i,
    .present_i(present), .hold_i(hold), .supply_ok_i, .ocp_i, .otp_i,
    .strobe_i(strobe), .run_o(run), .restart_o(restart),
    .in_sess_o(in_sess), .busy_o(busy),
    .pump_en_o, .vcc_en_o, .io_en_o, .clk_en_o, .card_rst_o
  );
endmodule

// File: tb/tb_smartcard_seq.sv
`timescale 1ns/1ps
module tb_smartcard_seq;
  localparam int H    = 4;
  localparam int HOLD = 40;

  logic clk_i = 0, rst_ni = 0;
  logic sess_req_ni = 1, host_rst_i = 0, pres_ni = 1, pres_i = 0;
  logic supply_ok_i = 1, ocp_i = 0, otp_i = 0;
  logic pump_en_o, vcc_en_o, io_en_o, clk_en_o, card_rst_o, irq_o;

  smartcard_seq #(.HALF_T(H), .HOLD_CYC(HOLD)) dut (.*);

  always #5 clk_i = ~clk_i;

  int vectors = 0, miscompares = 0;
  string tag = "R1";

  // reference model: 0 idle, 1 activating, 2 active, 3 shutting down
  int m_s, m_c, m_hold;
  bit m_pump, m_vcc, m_io, m_clk, m_rst, m_rst0, m_armed, m_flt;
  bit pres_s, insess, abrt, acc, n_armed, n_flt, n_rst;
  int n_hold;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_s = 0; m_c = 0; m_hold = HOLD;
      m_pump = 0; m_vcc = 0; m_io = 0; m_clk = 0; m_rst = 0;
      m_rst0 = 0; m_armed = 0; m_flt = 0;
    end else begin
      pres_s  = !pres_ni || pres_i;
      insess  = (m_s == 1) || (m_s == 2);
      abrt    = insess && (sess_req_ni || !pres_s || ocp_i || otp_i || !supply_ok_i);
      acc     = (m_s == 0) && m_armed && !sess_req_ni && pres_s && (m_hold == 0);
      n_armed = (m_s == 0) && sess_req_ni;
      n_flt   = sess_req_ni ? 1'b0 : (m_flt || (insess && (!pres_s || ocp_i || otp_i)));
      n_hold  = !supply_ok_i ? HOLD : (m_hold > 0 ? m_hold - 1 : 0);
      n_rst   = (m_s == 2) && !abrt && host_rst_i;
      case (m_s)
        0: if (acc) begin m_s = 1; m_c = 0; m_pump = 1; m_rst0 = host_rst_i; end
        1: if (abrt) begin m_s = 3; m_c = 0; end
           else begin
             m_c++;
             if (m_c >= 3*H+1) m_vcc = 1;
             if (m_c >= 8*H+1) m_io = 1;
             if (m_c >= 8*H+1 && (!m_rst0 || !host_rst_i || m_c >= 14*H+1)) m_clk = 1;
             if (m_c >= 14*H+1) m_s = 2;
           end
        2: if (abrt) begin m_s = 3; m_c = 0; end
        default: begin
          m_c++;
          if (m_c >= H+1)   m_clk = 0;
          if (m_c >= 2*H+1) m_io = 0;
          if (m_c >= 3*H+1) m_vcc = 0;
          if (m_c >= 10*H+1) begin m_pump = 0; m_s = 0; end
        end
      endcase
      m_armed = n_armed; m_flt = n_flt; m_hold = n_hold; m_rst = n_rst;
    end
  end

  function automatic logic [5:0] expv();
    logic irq_e;
    irq_e = m_flt ? 1'b0 : ((m_s != 0) ? 1'b1 : (!pres_ni || pres_i));
    return {m_pump, m_vcc, m_io, m_clk, m_rst, irq_e};
  endfunction

  always @(posedge clk_i) begin
    #2;
    if (rst_ni) begin
      vectors++;
      if ({pump_en_o, vcc_en_o, io_en_o, clk_en_o, card_rst_o, irq_o} !== expv()) begin
        miscompares++;
        $display("FAIL %s cycle compare: actual %b expected %b (pump,vcc,io,clk,rst,irq)",
                 tag, {pump_en_o, vcc_en_o, io_en_o, clk_en_o, card_rst_o, irq_o}, expv());
      end
    end
  end

  task automatic chk(string r, logic act, logic exp, string what);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %b expected %b", r, what, act, exp);
    end
  endtask

  task automatic wt(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #200000;
    miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset, no card
    wt(3);
    chk("R1", pump_en_o, 0, "pump in reset");
    chk("R1", irq_o, 0, "irq in reset, no card");
    rst_ni = 1;
    wt(2);
    chk("R1", vcc_en_o | io_en_o | clk_en_o | card_rst_o, 0, "enables after reset");

    // R10: request during power-up hold is ignored
    tag = "R10"; pres_ni = 0; wt(5);
    sess_req_ni = 0; wt(10); sess_req_ni = 1;
    chk("R10", pump_en_o, 0, "pump during hold");
    wt(HOLD);

    // R2: presence decoding in idle
    tag = "R2"; pres_ni = 1; pres_i = 1; wt(2);
    chk("R2", irq_o, 1, "irq with active-high switch");
    pres_i = 0; wt(2);
    chk("R2", irq_o, 0, "irq with no card");
    pres_ni = 0; wt(2);
    chk("R2", irq_o, 1, "irq with active-low switch");

    // R3/R12: request with no card, then card arrives while request held low
    tag = "R3"; pres_ni = 1; sess_req_ni = 0; wt(5);
    chk("R3", pump_en_o, 0, "pump without card");
    tag = "R12"; pres_ni = 0; wt(5);
    chk("R12", pump_en_o, 0, "pump without fresh request");
    sess_req_ni = 1; wt(3);

    // R4/R6: normal activation with host reset low
    tag = "R4"; sess_req_ni = 0; wt(14*H + 10);
    chk("R4", pump_en_o & vcc_en_o & io_en_o & clk_en_o, 1, "all enables on");
    tag = "R6"; host_rst_i = 1; wt(3);
    chk("R6", card_rst_o, 1, "card reset copies host");
    chk("R6", clk_en_o, 1, "clock kept");
    host_rst_i = 0; wt(3);
    chk("R6", card_rst_o, 0, "card reset low again");

    // R7: host ends session
    tag = "R7"; sess_req_ni = 1; wt(10*H + 5);
    chk("R7", pump_en_o | vcc_en_o, 0, "all off after shutdown");

    // R5: host reset high at start, released mid-window
    tag = "R5"; host_rst_i = 1; wt(2); sess_req_ni = 0; wt(8*H + 6);
    chk("R5", clk_en_o, 0, "clock held while host reset high");
    host_rst_i = 0; wt(3);
    chk("R5", clk_en_o, 1, "clock after host reset release");
    wt(8*H); sess_req_ni = 1; wt(10*H + 5);

    // R5: host reset high throughout activation
    host_rst_i = 1; wt(2); sess_req_ni = 0; wt(8*H + 10);
    chk("R5", clk_en_o, 0, "clock still gated");
    wt(6*H);
    chk("R5", clk_en_o, 1, "clock forced on at final step");
    chk("R5", card_rst_o, 1, "card reset follows host");
    host_rst_i = 0; sess_req_ni = 1; wt(10*H + 5);

    // R8/R9/R12: overcurrent
    tag = "R9"; sess_req_ni = 0; wt(14*H + 6);
    ocp_i = 1; wt(2);
    chk("R9", irq_o, 0, "irq on overcurrent");
    ocp_i = 0; wt(10*H + 5);
    chk("R8", pump_en_o, 0, "shutdown after overcurrent");
    chk("R9", irq_o, 0, "irq latched");
    chk("R12", pump_en_o, 0, "no restart with request still low");
    sess_req_ni = 1; wt(2);
    chk("R9", irq_o, 1, "irq cleared by request release");

    // overtemperature
    sess_req_ni = 0; wt(14*H + 6);
    otp_i = 1; wt(2); otp_i = 0;
    chk("R9", irq_o, 0, "irq on overtemperature");
    wt(10*H + 5); sess_req_ni = 1; wt(2);

    // card removal, card returns while latched
    sess_req_ni = 0; wt(14*H + 6);
    pres_ni = 1; wt(2); pres_ni = 0; wt(2);
    chk("R9", irq_o, 0, "irq latched after card returns");
    wt(10*H + 5);
    chk("R8", pump_en_o, 0, "shutdown after removal");
    sess_req_ni = 1; wt(2);

    // supply drop: emergency shutdown, irq kept high
    sess_req_ni = 0; wt(14*H + 6);
    supply_ok_i = 0; wt(2);
    chk("R9", irq_o, 1, "irq high on supply drop");
    supply_ok_i = 1; wt(10*H + 5);
    chk("R8", pump_en_o, 0, "shutdown after supply drop");
    sess_req_ni = 1; wt(HOLD + 5);

    // R11: abort early in activation
    tag = "R11"; sess_req_ni = 0; wt(2*H);
    sess_req_ni = 1; wt(2);
    chk("R11", vcc_en_o, 0, "supply never enabled");
    chk("R11", pump_en_o, 1, "pump still on during shutdown");
    wt(10*H + 5);
    chk("R11", pump_en_o, 0, "pump off");
    wt(3);
    finish_run();
  end
endmodule